// File: doc/BRIEF.md
# Fault-Remapping Cache Line Decoder

This block is the line decoder of a cache data/tag array that keeps working as lines wear out. It turns a set index into a one-hot word-line vector. A per-line fault flag marks each line as faulty or healthy. A reference whose own line is faulty is not lost. It is steered to a healthy line nearby in the binary decode tree. At every level of the tree, a subtree whose lines are all faulty is skipped, and the reference goes to the sibling subtree instead. With one faulty line, its references fall on the line it is paired with. With more faulty lines, references move up to the nearest healthy branch. The array must hold one extra tag bit per decode level so that lines shared this way can still tell their owners apart. Those tag bits are outside this block.

The fault flags sit in a shift chain. Reconfiguration loads them serially and they stay constant during normal operation. The index bits enter the tree in reverse order: the index MSB drives the leaf pairing stage. As a result, a line and the line that stands in for it are far apart in the address space. The block also reports the selected line as a binary number. When no healthy line remains, it raises an all-faulty indication and drives no word line.

Top module: `pad_remap_decoder`

## Requirements
- R1: Reset clears every fault flag, so after reset each index selects its directly decoded line and all_faulty is low.
- R2: With no faulty lines, exactly word line k is asserted, where line number bit j equals set_idx bit (3-j). The index MSB is line bit 0, and the index LSB picks between lines 0-7 and 8-15.
- R3: In each cycle with shift_en high, every flag moves to the next higher line number and serial_in enters as the flag of line 0. A flag value of 1 means faulty. After 16 shifts, the first bit shifted in is the flag of line 15 and the last is the flag of line 0.
- R4: While shift_en is low, the fault flags keep their values whatever serial_in does, and the index-to-line mapping does not change.
- R5: A reference to a faulty line whose pair partner (line number XOR 1) is healthy selects the partner.
- R6: Selection walks from the root. At each level it takes the half named by the index bit, unless every line in that half is faulty, in which case it takes the other half.
- R7: When three lines of an aligned group of four are faulty, every reference to any of the four lands on the one healthy line.
- R8: While at least one line is healthy, exactly one word line is asserted and it is never a faulty line.
- R9: When all lines are faulty, all_faulty is high, word_line is all zero and eff_line is zero.
- R10: eff_line is the binary number of the asserted word line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the fault-flag chain |
| rst_n | input | 1 | Active-low synchronous reset; clears all flags |
| shift_en | input | 1 | Shifts the fault-flag chain by one line this cycle |
| serial_in | input | 1 | Flag bit entering line 0 when shifting (1 = faulty) |
| set_idx | input | 4 | Set index to decode |
| word_line | output | 16 | One-hot line select after remapping |
| eff_line | output | 4 | Binary number of the selected line |
| all_faulty | output | 1 | High when no healthy line remains |

## Verification
The hardest situations to reach are those where remapping climbs more than one level: a whole half or quarter of the array faulty, or three lines of a four-line group faulty. Only there do the group-level select terms decide the result. Directed flag patterns build each of these shapes exactly, including every line faulty. Random flag patterns of sparse, medium and dense density then cover nested mixes. Each pattern is compared against a root-to-leaf walk model for all sixteen indexes.

// File: rtl/pad_pkg.sv
package pad_pkg;

  // Strobes from the configuration control to the flag datapath.
  typedef struct packed {
    logic shift;   // advance the flag chain this cycle
    logic bitIn;   // flag bit entering line 0
  } chainStrobe_t;

endpackage

// File: rtl/pad_cfg_ctrl.sv
module pad_cfg_ctrl
  import pad_pkg::*;
(
  input  logic         shift_en,
  input  logic         serial_in,
  output chainStrobe_t strobe
);

  // The serial bit only matters while shifting; hold it at zero otherwise
  // so the datapath sees a clean strobe bundle.
  always_comb begin
    strobe.shift = shift_en;
    strobe.bitIn = shift_en & serial_in;
  end

endmodule

// File: rtl/pad_flag_chain.sv
module pad_flag_chain
  import pad_pkg::*;
#(
  parameter int LINES = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  chainStrobe_t     strobe,
  output logic [LINES-1:0] fltFlags
);

  // Serial chain: new bit enters line 0, older bits move toward line LINES-1.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fltFlags <= '0;
    end else if (strobe.shift) begin
      fltFlags <= {fltFlags[LINES-2:0], strobe.bitIn};
    end
  end

endmodule

// File: rtl/pad_remap_tree.sv
module pad_remap_tree #(
  parameter int IDX_W       = 4,
  parameter bit REVERSE_IDX = 1'b1,
  localparam int LINES      = 1 << IDX_W
) (
  input  logic [IDX_W-1:0] setIdx,
  input  logic [LINES-1:0] fltFlags,
  output logic [LINES-1:0] wordLine,
  output logic [IDX_W-1:0] effLine,
  output logic             allFaulty
);

  // decAddr[l] is the address bit consumed at tree level l (level 0 = leaf pairs).
  logic [IDX_W-1:0] decAddr;

  generate
    if (REVERSE_IDX) begin : g_rev
      for (genvar b = 0; b < IDX_W; b++) begin : g_bit
        assign decAddr[b] = setIdx[IDX_W-1-b];
      end
    end else begin : g_fwd
      assign decAddr = setIdx;
    end
  endgenerate

  // grpFlt[l][n]: every line of the 2^l-line subtree n is faulty.
  logic [LINES-1:0] grpFlt [IDX_W+1];

  always_comb begin
    for (int l = 0; l <= IDX_W; l++) begin
      grpFlt[l] = '0;
    end
    grpFlt[0] = fltFlags;
    for (int l = 0; l < IDX_W; l++) begin
      for (int n = 0; n < LINES / 2; n++) begin
        if (n < (LINES >> (l + 1))) begin
          grpFlt[l+1][n] = grpFlt[l][2*n] & grpFlt[l][2*n+1];
        end
      end
    end
  end

  assign allFaulty = grpFlt[IDX_W][0];

  // selOk[l][k]: the level-l select term on the path of line k is true.
  // Even node: (!own & !a) | sibling ; odd node: (!own & a) | sibling.
  logic [LINES-1:0] selOk [IDX_W];
  logic [LINES-1:0] lineEn;

  always_comb begin
    for (int l = 0; l < IDX_W; l++) begin
      for (int k = 0; k < LINES; k++) begin
        int  node;
        logic ownF, sibF, side;
        node = k >> l;
        ownF = grpFlt[l][node];
        sibF = grpFlt[l][node ^ 1];
        side = node[0];
        selOk[l][k] = (!ownF && (decAddr[l] == side)) || sibF;
      end
    end
  end

  always_comb begin
    lineEn = '1;
    for (int l = 0; l < IDX_W; l++) begin
      lineEn = lineEn & selOk[l];
    end
  end

  assign wordLine = allFaulty ? '0 : lineEn;

  // Binary encoding of the (one-hot) selected line.
  always_comb begin
    effLine = '0;
    for (int k = 0; k < LINES; k++) begin
      if (wordLine[k]) begin
        effLine = effLine | IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/pad_remap_decoder.sv
module pad_remap_decoder
  import pad_pkg::*;
#(
  parameter int IDX_W       = 4,
  parameter bit REVERSE_IDX = 1'b1,
  localparam int LINES      = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             serial_in,
  input  logic [IDX_W-1:0] set_idx,
  output logic [LINES-1:0] word_line,
  output logic [IDX_W-1:0] eff_line,
  output logic             all_faulty
);

  chainStrobe_t     strobe;
  logic [LINES-1:0] fltFlags;

  pad_cfg_ctrl u_ctrl (
    .shift_en  (shift_en),
    .serial_in (serial_in),
    .strobe    (strobe)
  );

  pad_flag_chain #(.LINES(LINES)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .fltFlags (fltFlags)
  );

  pad_remap_tree #(.IDX_W(IDX_W), .REVERSE_IDX(REVERSE_IDX)) u_tree (
    .setIdx    (set_idx),
    .fltFlags  (fltFlags),
    .wordLine  (word_line),
    .effLine   (eff_line),
    .allFaulty (all_faulty)
  );

endmodule

// File: rtl/pad_remap_chk.sv
module pad_remap_chk #(
  parameter int IDX_W       = 4,
  parameter bit REVERSE_IDX = 1'b1,
  localparam int LINES      = 1 << IDX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             shift_en,
  input logic [IDX_W-1:0] set_idx,
  input logic [LINES-1:0] fltFlags,
  input logic [LINES-1:0] word_line,
  input logic [IDX_W-1:0] eff_line,
  input logic             all_faulty
);

  logic [IDX_W-1:0] directLine;

  always_comb begin
    for (int b = 0; b < IDX_W; b++) begin
      directLine[b] = REVERSE_IDX ? set_idx[IDX_W-1-b] : set_idx[b];
    end
  end

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(fltFlags)); // R4

  AST_DIRECT_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    (fltFlags == '0) |-> word_line[directLine]); // R2

  AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    !all_faulty |-> ($countones(word_line) == 1)); // R8

  AST_HEALTHY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (word_line & fltFlags) == '0); // R8

  AST_ALL_DEAD: assert property (@(posedge clk) disable iff (!rst_n)
    all_faulty |-> (word_line == '0 && eff_line == '0)); // R9

  AST_ENCODE: assert property (@(posedge clk) disable iff (!rst_n)
    !all_faulty |-> word_line[eff_line]); // R10

endmodule

bind pad_remap_decoder pad_remap_chk #(.IDX_W(IDX_W), .REVERSE_IDX(REVERSE_IDX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .shift_en   (shift_en),
  .set_idx    (set_idx),
  .fltFlags   (fltFlags),
  .word_line  (word_line),
  .eff_line   (eff_line),
  .all_faulty (all_faulty)
);

// File: tb/test_pad_remap_decoder.sv
module test_pad_remap_decoder;

  localparam int IW = 4;
  localparam int NL = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          shift_en = 1'b0;
  logic          serial_in = 1'b0;
  logic [IW-1:0] set_idx = '0;
  logic [NL-1:0] word_line;
  logic [IW-1:0] eff_line;
  logic          all_faulty;

  int  nChecks = 0;
  int  nFails = 0;
  bit  done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pad_remap_decoder i_pad_remap_decoder (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .serial_in  (serial_in),
    .set_idx    (set_idx),
    .word_line  (word_line),
    .eff_line   (eff_line),
    .all_faulty (all_faulty)
  );

  function automatic bit rangeDead(input logic [NL-1:0] f, input int lo, input int n);
    for (int i = lo; i < lo + n; i++) begin
      if (!f[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  // Root-to-leaf walk: level l uses index bit (IW-1-l); skip a fully faulty half.
  function automatic int refLine(input logic [NL-1:0] f, input int idx);
    int lo;
    int size;
    if (rangeDead(f, 0, NL)) return -1;
    lo = 0;
    size = NL;
    for (int l = IW - 1; l >= 0; l--) begin
      int half;
      int pick;
      half = size / 2;
      pick = ((idx >> (IW - 1 - l)) & 1) != 0 ? lo + half : lo;
      if (rangeDead(f, pick, half)) pick = (pick == lo) ? lo + half : lo;
      lo = pick;
      size = half;
    end
    return lo;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic checkIdx(input string req, input logic [NL-1:0] f, input int idx);
    int e;
    @(negedge clk);
    set_idx = IW'(idx);
    #1;
    e = refLine(f, idx);
    if (e < 0) begin
      chk(req, "all_faulty", int'(all_faulty), 1);
      chk(req, "word_line", int'(word_line), 0);
      chk(req, "eff_line", int'(eff_line), 0);
    end else begin
      chk(req, "all_faulty", int'(all_faulty), 0);
      chk(req, "word_line", int'(word_line), 1 << e);
      chk(req, "eff_line", int'(eff_line), e);
    end
  endtask

  task automatic checkAll(input string req, input logic [NL-1:0] f);
    for (int i = 0; i < NL; i++) checkIdx(req, f, i);
  endtask

  // Line NL-1 flag is shifted first, line 0 flag last.
  task automatic loadFlags(input logic [NL-1:0] f);
    for (int i = NL - 1; i >= 0; i--) begin
      @(negedge clk);
      shift_en = 1'b1;
      serial_in = f[i];
    end
    @(negedge clk);
    shift_en = 1'b0;
    serial_in = 1'b0;
  endtask

  function automatic int revIdx(input int line);
    int r;
    r = 0;
    for (int b = 0; b < IW; b++) if (((line >> b) & 1) != 0) r |= 1 << (IW - 1 - b);
    return r;
  endfunction

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      finishRun();
    end
  end

  initial begin
    logic [NL-1:0] f;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 / R2: reset state, direct mapping with bit-reversed index
    checkAll("R1", '0);
    for (int k = 0; k < NL; k++) begin
      @(negedge clk);
      set_idx = IW'(revIdx(k));
      #1;
      chk("R2", "word_line", int'(word_line), 1 << k);
    end

    // R3 / R5: single faulty line 5, partner 4 takes over (index 10 -> line 5)
    loadFlags(16'h0020);
    checkIdx("R3", 16'h0020, 10);
    chk("R5", "eff_line", int'(eff_line), 4);
    checkAll("R5", 16'h0020);

    // R4: toggle serial_in with shift_en low, mapping must not change
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      serial_in = ~serial_in;
    end
    @(negedge clk);
    serial_in = 1'b0;
    checkAll("R4", 16'h0020);

    // R3: partial shift of four ones after clearing: lines 0..3 faulty
    loadFlags('0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      shift_en = 1'b1;
      serial_in = 1'b1;
    end
    @(negedge clk);
    shift_en = 1'b0;
    serial_in = 1'b0;
    checkAll("R3", 16'h000F);

    // R3: only line 15 faulty -> its partner 14
    loadFlags(16'h8000);
    checkIdx("R3", 16'h8000, revIdx(15));
    chk("R3", "eff_line", int'(eff_line), 14);

    // R7: lines 0,1,3 faulty -> all of group 0..3 lands on line 2
    loadFlags(16'h000B);
    for (int k = 0; k < 4; k++) begin
      checkIdx("R7", 16'h000B, revIdx(k));
      chk("R7", "eff_line", int'(eff_line), 2);
    end

    // R6: lower half faulty -> line k goes to k+8
    loadFlags(16'h00FF);
    for (int k = 0; k < 8; k++) begin
      checkIdx("R6", 16'h00FF, revIdx(k));
      chk("R6", "eff_line", int'(eff_line), k + 8);
    end
    // R6: nested, quarter 4..7 and line 0 faulty
    loadFlags(16'h00F1);
    checkAll("R6", 16'h00F1);

    // R8: single healthy line 9
    loadFlags(16'hFDFF);
    checkAll("R8", 16'hFDFF);

    // R9: everything faulty
    loadFlags(16'hFFFF);
    checkAll("R9", 16'hFFFF);

    // R10 / R6 / R8: random patterns of several densities
    for (int t = 0; t < 300; t++) begin
      case (t % 3)
        0: f = NL'($urandom & $urandom & $urandom);
        1: f = NL'($urandom);
        default: f = NL'($urandom | $urandom);
      endcase
      loadFlags(f);
      checkAll("R10", f);
    end

    // R1: reset clears the flags again
    loadFlags(16'h5A5A);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    checkAll("R1", '0);

    done = 1'b1;
    finishRun();
  end

endmodule